// File: doc/BRIEF.md
# Bus Mastership Hold and Access Timeout Controller

This block sits on the requesting side of a shared system control bus. When the CPU side starts an access, the block raises a bus request, waits for the arbiter's grant and then presents the access to the bus until the bus reports ready. After the access ends, the request stays high for a programmed number of cycles. A second access that arrives inside that window goes onto the bus at once, with no new arbitration round, so a burst of back-to-back accesses keeps one mastership.

Each access is also guarded by a programmable timeout counted in CPU clock cycles. If the bus does not report ready in time, the block ends the access and pulses an error flag in place of the done pulse. The configuration word is split into two fields. The upper byte gives the hold window and the lower byte gives the timeout. A zero hold releases the bus right after each access, and a zero timeout turns the guard off.

Top module: `bus_hold_ctl`

## Requirements
- R1: After reset, bus_req_o, bus_cmd_o, acc_done_o and acc_err_o are all low.
- R2: An acc_start_i sampled high while idle sets bus_req_o in the next cycle. bus_cmd_o goes high in the cycle after bus_gnt_i is sampled high with the request pending.
- R3: bus_rdy_i sampled high while bus_cmd_o is high ends the access. In the next cycle acc_done_o is high for exactly one cycle and bus_cmd_o is low.
- R4: The hold length H is cfg_i[15:8]. With H greater than zero, bus_req_o stays high for exactly H cycles after an access ends and then drops, provided no new start arrives in that window.
- R5: An acc_start_i sampled high during the hold window sets bus_cmd_o in the next cycle, with no grant needed. The hold window restarts in full after that access ends.
- R6: With H equal to zero, bus_req_o is low in the same cycle that acc_done_o is high.
- R7: The timeout T is cfg_i[7:0]. With T greater than zero, if bus_rdy_i has not been sampled high during the first T cycles of bus_cmd_o, acc_err_o pulses for one cycle, acc_done_o stays low and bus_cmd_o drops.
- R8: With T equal to zero, an access waits for bus_rdy_i for as long as it takes and never raises acc_err_o.
- R9: If bus_rdy_i is sampled high in the very cycle the timeout is reached, the access completes normally. acc_done_o pulses and acc_err_o stays low.
- R10: acc_start_i is ignored while a request waits for its grant and while an access is on the bus. It changes neither bus_cmd_o nor the number of accesses that complete.
- R11: An acc_start_i sampled in the last cycle of the hold window is still issued without a new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_i | input | 16 | Configuration: [15:8] hold cycles, [7:0] timeout cycles |
| acc_start_i | input | 1 | CPU side: start an access |
| acc_done_o | output | 1 | CPU side: one-cycle pulse when an access completed |
| acc_err_o | output | 1 | CPU side: one-cycle pulse when an access timed out |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Grant from the arbiter |
| bus_cmd_o | output | 1 | Access presented on the bus |
| bus_rdy_i | input | 1 | Bus reports that the access finished |

## Verification
Every result appears one cycle after the edge that samples its cause. A start sampled in idle shows up on bus_req_o, a grant or a start in the hold window shows up on bus_cmd_o, and ready or the timeout shows up on the done and error pulses in the next cycle. The hold and timeout windows are counted from the first cycle of hold or of bus_cmd_o. The bench keeps a behavioural model that steps at the same rising edge as the design. Inputs are driven and all four outputs are compared at the falling edge, so each expected value is read in the exact cycle it is due. The directed sequences place ready, starts and grants on the first and last cycles of each window.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_HOLD = 2'd3
  } bh_state_e;
endpackage

// File: rtl/bh_cycle_cnt.sv
module bh_cycle_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr)     cnt_nxt = '0;
    else if (en) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr || en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/bh_ctrl_fsm.sv
module bh_ctrl_fsm
  import bh_pkg::*;
#(
  parameter int HW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          gnt,
  input  logic          rdy,
  input  logic [HW-1:0] hold_len,
  input  logic [TW-1:0] tmo_len,
  input  logic [HW-1:0] hold_cnt,
  input  logic [TW-1:0] tmo_cnt,
  output bh_state_e     state,
  output logic          done,
  output logic          err
);
  bh_state_e state_nxt;
  logic      done_nxt, err_nxt;
  logic      hold_last, tmo_hit;
  logic      hold_zero;

  assign hold_zero = (hold_len == '0);
  assign hold_last = (({1'b0, hold_cnt} + 1'b1) == {1'b0, hold_len});
  assign tmo_hit   = (tmo_len != '0) &&
                     (({1'b0, tmo_cnt} + 1'b1) == {1'b0, tmo_len});

  always_comb begin
    state_nxt = state;
    done_nxt  = 1'b0;
    err_nxt   = 1'b0;
    case (state)
      ST_IDLE: if (start) state_nxt = ST_WAIT;
      ST_WAIT: if (gnt)   state_nxt = ST_XFER;
      ST_XFER: begin
        if (rdy) begin
          done_nxt  = 1'b1;
          state_nxt = hold_zero ? ST_IDLE : ST_HOLD;
        end else if (tmo_hit) begin
          err_nxt   = 1'b1;
          state_nxt = hold_zero ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (start)          state_nxt = ST_XFER;
        else if (hold_last) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= done_nxt;
      err   <= err_nxt;
    end
  end
endmodule

// File: rtl/bus_hold_ctl.sv
module bus_hold_ctl
  import bh_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int TMO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [HOLD_W+TMO_W-1:0]   cfg_i,
  input  logic                      acc_start_i,
  output logic                      acc_done_o,
  output logic                      acc_err_o,
  output logic                      bus_req_o,
  input  logic                      bus_gnt_i,
  output logic                      bus_cmd_o,
  input  logic                      bus_rdy_i
);
  localparam int CFG_W = HOLD_W + TMO_W;

  logic              rst_meta_n, rst_sync_n;
  logic [HOLD_W-1:0] hold_len, hold_cnt;
  logic [TMO_W-1:0]  tmo_len, tmo_cnt;
  bh_state_e         state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign hold_len = cfg_i[CFG_W-1:TMO_W];
  assign tmo_len  = cfg_i[TMO_W-1:0];

  bh_cycle_cnt #(.W(HOLD_W)) u_hold_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (state != ST_HOLD),
    .en   (state == ST_HOLD),
    .cnt  (hold_cnt)
  );

  bh_cycle_cnt #(.W(TMO_W)) u_tmo_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (state != ST_XFER),
    .en   (state == ST_XFER),
    .cnt  (tmo_cnt)
  );

  bh_ctrl_fsm #(.HW(HOLD_W), .TW(TMO_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (acc_start_i),
    .gnt     (bus_gnt_i),
    .rdy     (bus_rdy_i),
    .hold_len(hold_len),
    .tmo_len (tmo_len),
    .hold_cnt(hold_cnt),
    .tmo_cnt (tmo_cnt),
    .state   (state),
    .done    (acc_done_o),
    .err     (acc_err_o)
  );

  assign bus_req_o = (state != ST_IDLE);
  assign bus_cmd_o = (state == ST_XFER);
endmodule

// File: rtl/bus_hold_ctl_chk.sv
module bus_hold_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_i,
  input logic        acc_start_i,
  input logic        acc_done_o,
  input logic        acc_err_o,
  input logic        bus_req_o,
  input logic        bus_gnt_i,
  input logic        bus_cmd_o,
  input logic        bus_rdy_i
);
  AST_CMD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o |-> bus_req_o); // R2
  AST_CMD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cmd_o) |-> $past(bus_gnt_i || acc_start_i)); // R5
  AST_DONE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done_o |-> $past(bus_cmd_o && bus_rdy_i)); // R3
  AST_ERR_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> $past(bus_cmd_o && !bus_rdy_i)); // R9
  AST_ERR_NEEDS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> ($past(cfg_i[7:0]) != 8'd0)); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_done_o && acc_err_o)); // R7
  AST_END_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done_o || acc_err_o) |-> !bus_cmd_o); // R3
endmodule

bind bus_hold_ctl bus_hold_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_i      (cfg_i),
  .acc_start_i(acc_start_i),
  .acc_done_o (acc_done_o),
  .acc_err_o  (acc_err_o),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_cmd_o  (bus_cmd_o),
  .bus_rdy_i  (bus_rdy_i)
);

// File: tb/bus_hold_ctl_tb.sv
module bus_hold_ctl_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] cfg;
  logic        start, gnt, rdy;
  logic        done, err, req, cmd;

  int n_vec  = 0;
  int n_fail = 0;
  string tag = "R1";

  // behavioural reference: 0 idle, 1 waiting grant, 2 on bus, 3 holding
  int m_st = 0, m_hc = 0, m_tc = 0;
  bit m_done = 0, m_err = 0;

  bus_hold_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .acc_start_i(start),
    .acc_done_o(done), .acc_err_o(err), .bus_req_o(req),
    .bus_gnt_i(gnt), .bus_cmd_o(cmd), .bus_rdy_i(rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    int h, t;
    h = int'(cfg[15:8]);
    t = int'(cfg[7:0]);
    if (!rst_n) begin
      m_st = 0; m_hc = 0; m_tc = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      case (m_st)
        0: if (start) m_st = 1;
        1: if (gnt) begin m_st = 2; m_tc = 0; end
        2: begin
          if (rdy) begin
            m_done = 1; m_st = (h == 0) ? 0 : 3; m_hc = 0;
          end else if (t != 0 && m_tc + 1 == t) begin
            m_err = 1; m_st = (h == 0) ? 0 : 3; m_hc = 0;
          end else m_tc++;
        end
        default: begin
          if (start) begin m_st = 2; m_tc = 0; end
          else if (m_hc + 1 == h) m_st = 0;
          else m_hc++;
        end
      endcase
    end
  end

  task automatic check1(string nm, logic act, logic exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    n_vec++;
    check1("bus_req_o",  req,  logic'(m_st != 0));
    check1("bus_cmd_o",  cmd,  logic'(m_st == 2));
    check1("acc_done_o", done, logic'(m_done));
    check1("acc_err_o",  err,  logic'(m_err));
  endtask

  task automatic cyc(logic s, logic g, logic r, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      start = s; gnt = g; rdy = r;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 0; gnt = 0; rdy = 0; cfg = 16'h030A;
    repeat (3) @(negedge clk);
    tag = "R1"; compare(); // R1 outputs low in reset
    rst_n = 1'b1;
    cyc(0, 0, 0, 4); // R1 idle after release

    // R2 R3 R4: grant after delay, ready later, hold 3 then release
    tag = "R4";
    cyc(1, 0, 0, 1); cyc(0, 0, 0, 2); cyc(0, 1, 0, 1);
    cyc(0, 0, 0, 2); cyc(0, 0, 1, 1); cyc(0, 0, 0, 6);

    // R5: second access in hold window, no grant
    cfg = 16'h0414; tag = "R5";
    cyc(1, 0, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 1); cyc(1, 0, 0, 1); cyc(0, 0, 0, 1); cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 3);
    // R11: start on last hold cycle
    tag = "R11";
    cyc(1, 0, 0, 1); cyc(0, 0, 1, 1); cyc(0, 0, 0, 7);

    // R6: zero hold
    cfg = 16'h0014; tag = "R6";
    cyc(1, 0, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 1, 1); cyc(0, 0, 0, 4);

    // R7: timeout of 5
    cfg = 16'h0205; tag = "R7";
    cyc(1, 0, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 0, 9); cyc(0, 0, 0, 4);

    // R8: timeout disabled, long wait
    cfg = 16'h0100; tag = "R8";
    cyc(1, 0, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 0, 300);
    cyc(0, 0, 1, 1); cyc(0, 0, 0, 4);

    // R9: ready on the cycle the timeout is reached
    cfg = 16'h0004; tag = "R9";
    cyc(1, 0, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 0, 3);
    cyc(0, 0, 1, 1); cyc(0, 0, 0, 4);

    // R10: start ignored while waiting and while on bus
    cfg = 16'h0200; tag = "R10";
    cyc(1, 0, 0, 1); cyc(1, 0, 0, 2); cyc(1, 1, 0, 1);
    cyc(1, 0, 0, 2); cyc(0, 0, 1, 1); cyc(0, 0, 0, 5);

    // R3: access ends on first cycle of command
    cfg = 16'h0103; tag = "R3";
    cyc(1, 0, 0, 1); cyc(0, 1, 1, 1); cyc(0, 0, 1, 1); cyc(0, 0, 0, 4);

    // R2: grant in same cycle as request appears
    tag = "R2";
    cyc(1, 1, 0, 1); cyc(0, 1, 0, 1); cyc(0, 0, 1, 1); cyc(0, 0, 0, 4);

    finish_run();
  end
endmodule